// File: doc/BRIEF.md
# Dual-Modulus Clock Divider

This block derives a slow clock from a fast reference clock. In single mode every output period lasts the same whole number of reference cycles. In dual mode the block alternates between two divisors. It emits a run of periods with the first divisor, then a run with the second, and then starts over. The long-run output rate is therefore a fraction of the reference rather than a plain integer ratio. A typical use is to approximate a 32.768 kHz timing clock from a reference that is not a power-of-two multiple of it.

Four 12-bit fields set the behaviour: divisor A, repeat count A, divisor B and repeat count B. Each field holds its value minus one. Together with the mode input, the fields are acted on only at the boundary between output periods. A one-cycle strobe marks the first reference cycle of every output period, so downstream logic can count or time the periods.

The control is a three-state machine:
- `PH_IDLE`: disabled or in reset.
- `PH_RUN_A`: running periods of divisor A.
- `PH_RUN_B`: running periods of divisor B.

Its transitions are:
- PH_IDLE to PH_RUN_A when the enable is sampled high.
- PH_RUN_A to PH_RUN_B at a period boundary in dual mode, once the A run is complete.
- PH_RUN_B to PH_RUN_A at a period boundary, once the B run is complete or dual mode has been dropped.
- Any state to PH_IDLE when the enable is sampled low.

The machine stays in PH_RUN_A or PH_RUN_B at every other boundary.

Top module: `dualmod_clkdiv`

## Requirements
- R1: With `dual_mode` at 0, every output period lasts `div_a_fld`+1 reference cycles, and `div_b_fld`, `rep_a_fld` and `rep_b_fld` have no effect on the output.
- R2: With `dual_mode` at 1, the block emits `rep_a_fld`+1 consecutive periods of `div_a_fld`+1 cycles, then `rep_b_fld`+1 consecutive periods of `div_b_fld`+1 cycles, and repeats this pattern for as long as it stays enabled.
- R3: Every field is 12 bits wide and encodes its value minus one, so a field value of 0 means 1 and a field value of 4095 means 4096.
- R4: Over a whole number of dual-mode sequences, the total reference-cycle count equals (n1·m1 + n2·m2) per sequence for (m1 + m2) output periods, where n and m are the decoded divisors and repeat counts.
- R5: In each output period of divisor n > 1, `clk_out` is high for the first floor(n/2) reference cycles and low for the rest.
- R6: While the divisor in use is 1, `clk_out` follows `clk_ref` directly, and a strobe is issued on every reference cycle.
- R7: A change to the mode or to any field takes effect only at the next period boundary. A change that is present at the edge that ends a period governs the period that follows that edge.
- R8: While `rst_n` is low, or from the first clock edge at which `en` is sampled low, `clk_out` and `period_stb` are low and all counting is cleared. The next enabled run always begins with divisor A.
- R9: `period_stb` is high for exactly one reference cycle at the start of each output period. The first strobe follows the first edge at which `en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the output quiet and restarts the sequence |
| dual_mode | input | 1 | 0 = single divisor A, 1 = alternate A and B |
| div_a_fld | input | 12 | Divisor A minus one |
| rep_a_fld | input | 12 | Repeat count A minus one |
| div_b_fld | input | 12 | Divisor B minus one |
| rep_b_fld | input | 12 | Repeat count B minus one |
| clk_out | output | 1 | Divided clock |
| period_stb | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The delicate coincidence is a configuration change that lands on the same edge that closes a period. In that one cycle, the boundary logic chooses the next divisor and the phase machine decides whether to switch runs. The bench provokes this by changing divisor A exactly on the last reference cycle of a period, and again by changing it in the middle of a period. Each measured period length is judged against the expected order: the old divisor runs to completion, and the new one takes over from the very next period. A disable that lands in the middle of a B run is also checked, to confirm that the restart begins with divisor A.

// File: rtl/dmdiv_pkg.sv
`timescale 1ns/1ps
package dmdiv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN_A = 2'd1,
        PH_RUN_B = 2'd2
    } phase_e;

endpackage

// File: rtl/dmdiv_phase_fsm.sv
`timescale 1ns/1ps
module dmdiv_phase_fsm
    import dmdiv_pkg::*;
#(
    parameter int FLD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dual,
    input  logic [FLD_W-1:0] rep_a,
    input  logic [FLD_W-1:0] rep_b,
    input  logic             wrap,
    output phase_e           state_q,
    output logic             start,
    output logic             sel_b,
    output logic             active
);

    phase_e           state_d;
    logic [FLD_W-1:0] rep_q;
    logic [FLD_W-1:0] rep_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            rep_q   <= rep_d;
        end
    end

    // next-state logic: decisions are made only at a period boundary
    always_comb begin
        state_d = state_q;
        rep_d   = rep_q;
        start   = 1'b0;
        if (!en) begin
            state_d = PH_IDLE;
            rep_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d = PH_RUN_A;
                    rep_d   = '0;
                    start   = 1'b1;
                end
                PH_RUN_A: begin
                    if (wrap) begin
                        start = 1'b1;
                        if (dual && (rep_q >= rep_a)) begin
                            state_d = PH_RUN_B;
                            rep_d   = '0;
                        end else if (dual) begin
                            rep_d = FLD_W'(rep_q + 1'b1);
                        end else begin
                            rep_d = '0;
                        end
                    end
                end
                PH_RUN_B: begin
                    if (wrap) begin
                        start = 1'b1;
                        if (!dual || (rep_q >= rep_b)) begin
                            state_d = PH_RUN_A;
                            rep_d   = '0;
                        end else begin
                            rep_d = FLD_W'(rep_q + 1'b1);
                        end
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    rep_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        active = (state_q != PH_IDLE);
        sel_b  = (state_d == PH_RUN_B);
    end

endmodule

// File: rtl/dmdiv_period_ctr.sv
`timescale 1ns/1ps
module dmdiv_period_ctr #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic [CNT_W-1:0] load_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cur_n_q,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cur_n_q <= ONE;
        end else if (!en) begin
            cnt_q   <= '0;
        end else if (start) begin
            cnt_q   <= '0;
            cur_n_q <= load_n;
        end else begin
            cnt_q   <= CNT_W'(cnt_q + 1'b1);
        end
    end

    always_comb begin
        wrap = (cnt_q == CNT_W'(cur_n_q - ONE));
    end

endmodule

// File: rtl/dmdiv_out_stage.sv
`timescale 1ns/1ps
module dmdiv_out_stage #(
    parameter int CNT_W = 13
) (
    input  logic             clk_ref,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cur_n,
    output logic             clk_out,
    output logic             period_stb
);

    logic [CNT_W-1:0] half_n;
    logic             bypass;

    always_comb begin
        half_n     = cur_n >> 1;
        bypass     = (cur_n == CNT_W'(1));
        period_stb = active && (cnt == '0);
        if (!active)
            clk_out = 1'b0;
        else if (bypass)
            clk_out = clk_ref;
        else
            clk_out = (cnt < half_n);
    end

endmodule

// File: rtl/dualmod_clkdiv.sv
`timescale 1ns/1ps
module dualmod_clkdiv
    import dmdiv_pkg::*;
#(
    parameter int FLD_W = 12
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dual_mode,
    input  logic [FLD_W-1:0] div_a_fld,
    input  logic [FLD_W-1:0] rep_a_fld,
    input  logic [FLD_W-1:0] div_b_fld,
    input  logic [FLD_W-1:0] rep_b_fld,
    output logic             clk_out,
    output logic             period_stb
);

    localparam int CNT_W = FLD_W + 1;

    phase_e           phase_q;
    logic             start;
    logic             sel_b;
    logic             active;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cur_n;
    logic [CNT_W-1:0] load_n;

    // decode the chosen divisor field (value minus one) into a cycle count
    always_comb begin
        if (sel_b)
            load_n = {1'b0, div_b_fld} + 1'b1;
        else
            load_n = {1'b0, div_a_fld} + 1'b1;
    end

    dmdiv_phase_fsm #(.FLD_W(FLD_W)) u_fsm (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .en      (en),
        .dual    (dual_mode),
        .rep_a   (rep_a_fld),
        .rep_b   (rep_b_fld),
        .wrap    (wrap),
        .state_q (phase_q),
        .start   (start),
        .sel_b   (sel_b),
        .active  (active)
    );

    dmdiv_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .en      (en),
        .start   (start),
        .load_n  (load_n),
        .cnt_q   (cnt),
        .cur_n_q (cur_n),
        .wrap    (wrap)
    );

    dmdiv_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk_ref    (clk_ref),
        .active     (active),
        .cnt        (cnt),
        .cur_n      (cur_n),
        .clk_out    (clk_out),
        .period_stb (period_stb)
    );

endmodule

// File: rtl/dmdiv_checker.sv
`timescale 1ns/1ps
module dmdiv_checker
    import dmdiv_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             dual,
    input logic             period_stb,
    input phase_e           state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cur_n
);

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !period_stb); // R8

    AST_FIRST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> period_stb); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_stb && en && (cur_n != CNT_W'(1))) |=> !period_stb); // R9

    AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_n) |-> period_stb); // R7

    AST_B_AFTER_A: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RUN_B && $past(state) != PH_RUN_B)
            |-> ($past(state) == PH_RUN_A && $past(dual))); // R2

    AST_RESTART_A: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PH_IDLE && state != PH_IDLE) |-> state == PH_RUN_A); // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE) |-> (cnt < cur_n)); // R1

endmodule

bind dualmod_clkdiv dmdiv_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .en         (en),
    .dual       (dual_mode),
    .period_stb (period_stb),
    .state      (phase_q),
    .cnt        (cnt),
    .cur_n      (cur_n)
);

// File: tb/dualmod_clkdiv_bench.sv
`timescale 1ns/1ps
module dualmod_clkdiv_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        dual = 1'b0;
    logic [11:0] fa = '0, ra = '0, fb = '0, rb = '0;
    logic        clk_out;
    logic        stb;

    typedef struct {
        int    len;
        int    hi;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   sum_len = 0;
    int   per_seen = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    dualmod_clkdiv u_dualmod_clkdiv (
        .clk_ref    (clk),
        .rst_n      (rst_n),
        .en         (en),
        .dual_mode  (dual),
        .div_a_fld  (fa),
        .rep_a_fld  (ra),
        .div_b_fld  (fb),
        .rep_b_fld  (rb),
        .clk_out    (clk_out),
        .period_stb (stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push(input int n, input string tag);
        exp_t e;
        e.len = n;
        e.hi  = n / 2;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        #1;
    endtask

    task automatic stop_run();
        en = 1'b0;
        cyc(2);
        chk(clk_out == 1'b0, "R8 clk_out low when disabled", int'(clk_out), 0);
        chk(stb == 1'b0, "R8 strobe low when disabled", int'(stb), 0);
    endtask

    // monitor: measures every complete output period and scores it
    initial begin
        int len;
        int hi;
        bit have;
        len = 0; hi = 0; have = 1'b0;
        forever begin
            @(negedge clk);
            if (!en || !rst_n) begin
                have = 1'b0;
            end else if (stb) begin
                if (have && exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(len == e.len, {e.tag, " period length"}, len, e.len);
                    chk(hi == e.hi, {"R5 high time / ", e.tag}, hi, e.hi);
                    sum_len += len;
                    per_seen++;
                end
                have = 1'b1;
                len  = 1;
                hi   = int'(clk_out);
            end else if (have) begin
                len++;
                hi += int'(clk_out);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(4);
        chk(clk_out == 1'b0, "R8 reset clk_out", int'(clk_out), 0);
        chk(stb == 1'b0, "R8 reset strobe", int'(stb), 0);
        rst_n = 1'b1;
        cyc(2);

        // R1: single mode, B fields and repeat counts set to noise
        fa = 12'd5; fb = 12'd2; ra = 12'd3; rb = 12'd7; dual = 1'b0;
        push(6, "R1"); push(6, "R1"); push(6, "R1");
        en = 1'b1;
        @(negedge clk);
        chk(stb == 1'b1, "R9 first strobe after enable", int'(stb), 1);
        @(negedge clk);
        chk(stb == 1'b0, "R9 strobe lasts one cycle", int'(stb), 0);
        drain();
        stop_run();

        // R7: change in the middle of a period
        fa = 12'd5; ra = '0; fb = '0; rb = '0;
        push(6, "R7 old divisor completes");
        push(3, "R7 new divisor"); push(3, "R7 new divisor");
        en = 1'b1;
        @(negedge clk);
        cyc(2);
        fa = 12'd2;
        drain();
        stop_run();

        // R7: change lands on the edge that ends the period
        fa = 12'd4;
        push(5, "R7 boundary old"); push(2, "R7 boundary new"); push(2, "R7 boundary new");
        en = 1'b1;
        @(negedge clk);
        repeat (4) @(negedge clk);
        #1;
        fa = 12'd1;
        drain();
        stop_run();

        // R2 / R4: dual interleave, n1=4 m1=3, n2=5 m2=2
        fa = 12'd3; ra = 12'd2; fb = 12'd4; rb = 12'd1; dual = 1'b1;
        sum_len = 0; per_seen = 0;
        for (int s = 0; s < 2; s++) begin
            push(4, "R2 A run"); push(4, "R2 A run"); push(4, "R2 A run");
            push(5, "R2 B run"); push(5, "R2 B run");
        end
        en = 1'b1;
        drain();
        chk(sum_len == 2 * (4 * 3 + 5 * 2), "R4 cycles over two sequences", sum_len, 44);
        chk(per_seen == 2 * (3 + 2), "R4 periods over two sequences", per_seen, 10);

        // R8: disable in the middle of the B run, then restart with A
        push(4, "R2 A run"); push(4, "R2 A run"); push(4, "R2 A run"); push(5, "R2 B run");
        drain();
        stop_run();
        push(4, "R8 restart with A"); push(4, "R8 restart with A");
        push(4, "R8 restart with A"); push(5, "R8 then B");
        en = 1'b1;
        drain();

        // R8: reset in the middle of a run
        cyc(3);
        rst_n = 1'b0;
        #1;
        chk(clk_out == 1'b0, "R8 reset mid-run clk_out", int'(clk_out), 0);
        chk(stb == 1'b0, "R8 reset mid-run strobe", int'(stb), 0);
        cyc(2);
        push(4, "R8 after reset A"); push(4, "R8 after reset A"); push(4, "R8 after reset A");
        rst_n = 1'b1;
        drain();
        stop_run();

        // R3: single repeat counts (field 0) and the largest divisor
        fa = 12'd1; fb = 12'd2; ra = '0; rb = '0; dual = 1'b1;
        push(2, "R3 count field 0 A"); push(3, "R3 count field 0 B");
        push(2, "R3 count field 0 A"); push(3, "R3 count field 0 B");
        en = 1'b1;
        drain();
        stop_run();
        fa = 12'd4095; dual = 1'b0;
        push(4096, "R3 field 4095");
        en = 1'b1;
        drain();
        stop_run();

        // R6: divisor 1 passes the reference through
        fa = 12'd0;
        push(1, "R6 bypass"); push(1, "R6 bypass"); push(1, "R6 bypass");
        en = 1'b1;
        cyc(2);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #2;
            chk(clk_out == 1'b1, "R6 follows reference high", int'(clk_out), 1);
            chk(stb == 1'b1, "R6 strobe every cycle", int'(stb), 1);
            @(negedge clk);
            #1;
            chk(clk_out == 1'b0, "R6 follows reference low", int'(clk_out), 0);
        end
        drain();
        stop_run();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule